// File: doc/BRIEF.md
# Multi-Channel Compare-Match Event Timer

This block keeps one free-running 32-bit tick counter and a small bank of compare channels behind a flat 32-bit register port. Software programs a channel with a match value. When the counter reaches that value, the channel raises its interrupt request. A channel can fire once (one-shot), or it can re-arm itself by adding a stored increment after every match (periodic). Each channel reports the interrupt line it is routed to. A global legacy-routing switch pins the first two channels to fixed lines, whatever their own route fields say.

The register port is synchronous for writes and combinational for reads. The counter only advances while the global run bit is set. It can be written directly, and it wraps modulo 2^32. An interrupt is either a one-cycle pulse (edge) or a latched status bit (level) that software clears by writing ones to the status register.

Top module: `evt_timer`

## Requirements
- R1: The identity word at 0x000 reads vendor in bits 31:16, a legacy-capable flag in bit 15, the channel count minus one in bits 12:8 and the revision in bits 7:0 (defaults give 0x1A2B8205). The tick-period word at 0x004 reads the nonzero femtosecond period (default 10,000,000), and writes to it are ignored.
- R2: The counter at 0x0F0 increments by one per clock only while the run bit (bit 0 of the control word at 0x010) is 1. It holds otherwise, can be loaded by a write, and wraps from 0xFFFFFFFF to 0.
- R3: A channel matches when the running counter equals its comparator (channel n config at 0x100+0x20*n, comparator at +0x08). With interrupt-enable (config bit 2) set and type bit 1 clear, irq_req pulses for exactly one cycle, visible while the counter reads comparator+1. The status bit is not set, and with interrupt-enable clear there is no pulse.
- R4: With type bit 1 set (level), a match sets the channel's status bit, and irq_req stays high from the cycle the counter reads comparator+1 until that status bit is cleared.
- R5: The status register at 0x020 holds bit n for channel n. Writing 1 to a bit clears it, writing 0 leaves it, and writing all ones clears every bit.
- R6: In one-shot mode (config bit 3 clear) the comparator keeps its value after a match.
- R7: In periodic mode with set-value (config bit 6) set, the first comparator write loads the next match value and the second loads the increment. Set-value then reads 0, and each match adds the increment to the comparator.
- R8: In periodic mode with set-value clear, a comparator write changes only the next match value, and the stored increment is kept.
- R9: Config bit 4 reads 1 only on channels able to run periodically (channels 0 and 1 by default). On other channels the periodic bit cannot be set and reads 0.
- R10: With the legacy bit (bit 1 of the control word) set, channel 0 reports line 0 and channel 1 reports line 8. Otherwise each channel reports its route field (config bits 13:9). The word at channel +0x04 reads the allowed-line mask (default 0x00F00F01).
- R11: After reset the control, status, counter and comparator registers read 0 and no interrupt is requested.

Config word bits 1, 2, 3, 6, 8 and 13:9 are writable. Bit 8 (force-32) is stored and read back only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_req | output | NUM_CH | Interrupt request per channel |
| irq_line | output | NUM_CH*5 | Routed interrupt line index per channel, channel n in bits 5n+4:5n |

## Verification
The bench watches the counter and each request line together, so it can catch a match taken one tick early or late, or a match taken with a greater-or-equal compare. Either fault would move the pulse off comparator+1 or repeat it. The two-write set-value sequence is checked both between the writes and after them. A design that cleared set-value on the first write would load the increment as the next match value, and a design that never cleared it would keep treating later writes as increments. Level status is checked against writes of zero, writes to another bit and writes of all ones, which exposes a plain-write status register or a missing hold. Counter wrap and the legacy override of the route fields are also probed, so a saturating counter or a legacy decode on the wrong channel would show up.

// File: rtl/evt_pkg.sv
// Package evt_pkg
// Shared register map, field positions and helpers for the event timer.
// Assumes byte addressing with 32-bit aligned registers.
package evt_pkg;

    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int MAX_CH  = 8;
    localparam int RT_W    = 5;
    localparam int CH_SH   = 5;

    localparam logic [AW-1:0] A_IDENT  = 12'h000;
    localparam logic [AW-1:0] A_PERIOD = 12'h004;
    localparam logic [AW-1:0] A_CTRL   = 12'h010;
    localparam logic [AW-1:0] A_STAT   = 12'h020;
    localparam logic [AW-1:0] A_COUNT  = 12'h0F0;
    localparam logic [3:0]    A_CH_PAGE = 4'h1;

    localparam logic [CH_SH-1:0] O_CFG    = 5'h00;
    localparam logic [CH_SH-1:0] O_ROUTES = 5'h04;
    localparam logic [CH_SH-1:0] O_CMP    = 5'h08;

    localparam int B_LVL  = 1;
    localparam int B_IEN  = 2;
    localparam int B_PER  = 3;
    localparam int B_PCAP = 4;
    localparam int B_SETV = 6;
    localparam int B_F32  = 8;
    localparam int B_RT   = 9;

    localparam int G_RUN  = 0;
    localparam int G_LEG  = 1;

    localparam logic [RT_W-1:0] LEG_LINE0 = 5'd0;
    localparam logic [RT_W-1:0] LEG_LINE1 = 5'd8;

    localparam int CHI_W = AW - 4 - CH_SH;

    // True when the address falls in the per-channel page
    function automatic logic ch_page(input logic [AW-1:0] a);
        return a[AW-1:AW-4] == A_CH_PAGE;
    endfunction

    // Channel index inside the per-channel page
    function automatic logic [CHI_W-1:0] ch_idx(input logic [AW-1:0] a);
        return a[AW-5:CH_SH];
    endfunction

    // Register offset inside one channel window
    function automatic logic [CH_SH-1:0] ch_off(input logic [AW-1:0] a);
        return a[CH_SH-1:0];
    endfunction

endpackage

// File: rtl/evt_main_counter.sv
// Module evt_main_counter
// Free-running tick counter: loads on request, otherwise steps by one while
// run is high. Wraps naturally modulo 2^W. Assumes load wins over stepping.
module evt_main_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);

    // Counter state: reset, load or step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (run)
            cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/evt_channel.sv
// Module evt_channel
// One compare channel: config fields, comparator with optional periodic
// increment, two-write set-value sequencing, level status and edge pulse.
// Assumes cfg_we and cmp_we are never high together (distinct addresses).
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PER_OK = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   cnt,
    input  logic            run,
    input  logic            cfg_we,
    input  logic            cmp_we,
    input  logic [DW-1:0]   wdata,
    input  logic            clr,
    output logic [DW-1:0]   cfg_rd,
    output logic [DW-1:0]   cmp_q,
    output logic            status_q,
    output logic            irq,
    output logic [RT_W-1:0] route_q
);

    logic          lvl_q, ien_q, per_q, setv_q, f32_q, half_q, edge_q;
    logic [DW-1:0] incr_q;
    logic          match;
    logic          second_wr;

    assign match     = run && (cnt == cmp_q);
    assign second_wr = cmp_we && per_q && setv_q && half_q;

    // Config fields; set-value drops after the increment write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            ien_q   <= 1'b0;
            per_q   <= 1'b0;
            setv_q  <= 1'b0;
            f32_q   <= 1'b0;
            route_q <= '0;
        end else if (cfg_we) begin
            lvl_q   <= wdata[B_LVL];
            ien_q   <= wdata[B_IEN];
            per_q   <= PER_OK & wdata[B_PER];
            setv_q  <= wdata[B_SETV];
            f32_q   <= wdata[B_F32];
            route_q <= wdata[B_RT +: RT_W];
        end else if (second_wr) begin
            setv_q  <= 1'b0;
        end
    end

    // Comparator, increment and write-phase tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            incr_q <= '0;
            half_q <= 1'b0;
        end else if (cmp_we) begin
            if (per_q && setv_q) begin
                if (!half_q) begin
                    cmp_q  <= wdata;
                    half_q <= 1'b1;
                end else begin
                    incr_q <= wdata;
                    half_q <= 1'b0;
                end
            end else begin
                cmp_q <= wdata;
            end
        end else begin
            if (match && per_q)
                cmp_q <= cmp_q + incr_q;
            if (cfg_we)
                half_q <= 1'b0;
        end
    end

    // Level status: a match sets it, write-one clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (match && lvl_q)
            status_q <= 1'b1;
        else if (clr)
            status_q <= 1'b0;
    end

    // Edge pulse register, one cycle per match
    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_q <= 1'b0;
        else
            edge_q <= match && ien_q && !lvl_q;
    end

    // Request output and config readback
    always_comb begin
        irq                 = edge_q | (status_q & ien_q);
        cfg_rd              = '0;
        cfg_rd[B_LVL]       = lvl_q;
        cfg_rd[B_IEN]       = ien_q;
        cfg_rd[B_PER]       = per_q;
        cfg_rd[B_PCAP]      = PER_OK;
        cfg_rd[B_SETV]      = setv_q;
        cfg_rd[B_F32]       = f32_q;
        cfg_rd[B_RT +: RT_W] = route_q;
    end

endmodule

// File: rtl/evt_readback.sv
// Module evt_readback
// Combinational read multiplexer over global and per-channel registers.
// Assumes unmapped addresses read as zero.
module evt_readback
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           ident,
    input  logic [DW-1:0]           period,
    input  logic [DW-1:0]           ctrl,
    input  logic [NUM_CH-1:0]       status,
    input  logic [DW-1:0]           cnt,
    input  logic [DW-1:0]           route_mask,
    input  logic [NUM_CH-1:0][DW-1:0] cfg_rd,
    input  logic [NUM_CH-1:0][DW-1:0] cmp,
    output logic [DW-1:0]           rdata
);

    // Address decode and data selection
    always_comb begin
        rdata = '0;
        if (addr == A_IDENT)
            rdata = ident;
        else if (addr == A_PERIOD)
            rdata = period;
        else if (addr == A_CTRL)
            rdata = ctrl;
        else if (addr == A_STAT)
            rdata = DW'(status);
        else if (addr == A_COUNT)
            rdata = cnt;
        else if (ch_page(addr)) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx(addr) == CHI_W'(i)) begin
                    if (ch_off(addr) == O_CFG)
                        rdata = cfg_rd[i];
                    else if (ch_off(addr) == O_ROUTES)
                        rdata = route_mask;
                    else if (ch_off(addr) == O_CMP)
                        rdata = cmp[i];
                end
            end
        end
    end

endmodule

// File: rtl/evt_timer.sv
// Module evt_timer
// Top of the event timer: control register, write decode, main counter,
// a generated bank of compare channels, line routing and readback.
// Assumes 2 <= NUM_CH <= 8 and a single-cycle register write strobe.
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NUM_CH     = 3,
    parameter logic [15:0] VENDOR     = 16'h1A2B,
    parameter logic [7:0]  REV        = 8'h05,
    parameter logic [31:0] PERIOD_FS  = 32'd10_000_000,
    parameter logic [31:0] ROUTE_MASK = 32'h00F00F01,
    parameter logic [MAX_CH-1:0] PER_CAP = 8'h03
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          reg_addr,
    input  logic                   reg_we,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    output logic [NUM_CH-1:0]      irq_req,
    output logic [NUM_CH*RT_W-1:0] irq_line
);

    localparam logic [DW-1:0] IDENT = {VENDOR, 1'b1, 2'b00, 5'(NUM_CH - 1), REV};

    logic                      gcfg_en, gcfg_leg;
    logic [DW-1:0]             ctrl_word;
    logic [DW-1:0]             cnt;
    logic                      cnt_wr, stat_wr, ctrl_wr;
    logic [NUM_CH-1:0]         cfg_wr, cmp_wr;
    logic [NUM_CH-1:0]         status_vec, lvl_vec, per_vec;
    logic [NUM_CH-1:0][DW-1:0] cfg_vec, cmp_vec;
    logic [NUM_CH-1:0][RT_W-1:0] route_vec;

    // Global write decode
    always_comb begin
        ctrl_wr = reg_we && (reg_addr == A_CTRL);
        stat_wr = reg_we && (reg_addr == A_STAT);
        cnt_wr  = reg_we && (reg_addr == A_COUNT);
    end

    // Control register: run and legacy-route bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_en  <= 1'b0;
            gcfg_leg <= 1'b0;
        end else if (ctrl_wr) begin
            gcfg_en  <= reg_wdata[G_RUN];
            gcfg_leg <= reg_wdata[G_LEG];
        end
    end

    // Control word readback assembly
    always_comb begin
        ctrl_word        = '0;
        ctrl_word[G_RUN] = gcfg_en;
        ctrl_word[G_LEG] = gcfg_leg;
    end

    evt_main_counter #(.W(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gcfg_en),
        .ld     (cnt_wr),
        .ld_val (reg_wdata),
        .cnt    (cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;

        // Per-channel write decode
        always_comb begin
            sel       = reg_we && ch_page(reg_addr) && (ch_idx(reg_addr) == CHI_W'(i));
            cfg_wr[i] = sel && (ch_off(reg_addr) == O_CFG);
            cmp_wr[i] = sel && (ch_off(reg_addr) == O_CMP);
        end

        evt_channel #(.PER_OK(PER_CAP[i])) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .run      (gcfg_en),
            .cfg_we   (cfg_wr[i]),
            .cmp_we   (cmp_wr[i]),
            .wdata    (reg_wdata),
            .clr      (stat_wr && reg_wdata[i]),
            .cfg_rd   (cfg_vec[i]),
            .cmp_q    (cmp_vec[i]),
            .status_q (status_vec[i]),
            .irq      (irq_req[i]),
            .route_q  (route_vec[i])
        );

        // Mode flags for the checker
        always_comb begin
            lvl_vec[i] = cfg_vec[i][B_LVL];
            per_vec[i] = cfg_vec[i][B_PER];
        end

        // Line routing with the legacy override on the first two channels
        if (i == 0) begin : g_leg0
            assign irq_line[i*RT_W +: RT_W] = gcfg_leg ? LEG_LINE0 : route_vec[i];
        end else if (i == 1) begin : g_leg1
            assign irq_line[i*RT_W +: RT_W] = gcfg_leg ? LEG_LINE1 : route_vec[i];
        end else begin : g_plain
            assign irq_line[i*RT_W +: RT_W] = route_vec[i];
        end
    end

    evt_readback #(.NUM_CH(NUM_CH)) u_rd (
        .addr       (reg_addr),
        .ident      (IDENT),
        .period     (PERIOD_FS),
        .ctrl       (ctrl_word),
        .status     (status_vec),
        .cnt        (cnt),
        .route_mask (ROUTE_MASK),
        .cfg_rd     (cfg_vec),
        .cmp        (cmp_vec),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/evt_timer_chk.sv
// Module evt_timer_chk
// Temporal checks on the event timer, bound into evt_timer.
// Assumes it sees the top's internal state through the bind connections.
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      gcfg_en,
    input logic                      gcfg_leg,
    input logic                      cnt_wr,
    input logic                      stat_wr,
    input logic [NUM_CH-1:0]         clr_bits,
    input logic [DW-1:0]             cnt,
    input logic [NUM_CH-1:0]         cmp_wr,
    input logic [NUM_CH-1:0]         lvl_vec,
    input logic [NUM_CH-1:0]         per_vec,
    input logic [NUM_CH-1:0]         status_vec,
    input logic [NUM_CH-1:0][DW-1:0] cmp_vec,
    input logic [NUM_CH-1:0]         irq_req,
    input logic [NUM_CH*RT_W-1:0]    irq_line
);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gcfg_en && !cnt_wr) |=> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gcfg_en && !cnt_wr) |=> (cnt == $past(cnt) + 32'd1));

    // R10
    legacy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gcfg_leg |-> (irq_line[RT_W-1:0] == LEG_LINE0 &&
                      irq_line[2*RT_W-1:RT_W] == LEG_LINE1));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
        // R5
        status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && clr_bits[i] && !(gcfg_en && lvl_vec[i] && cnt == cmp_vec[i]))
            |=> !status_vec[i]);

        // R4
        status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_vec[i]) |-> $past(stat_wr && clr_bits[i]));

        // R6
        oneshot_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!per_vec[i] && !cmp_wr[i]) |=> $stable(cmp_vec[i]));

        // R3
        edge_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[i] && !lvl_vec[i] && !status_vec[i])
            |-> $past(gcfg_en && cnt == cmp_vec[i]));
    end

endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gcfg_en    (gcfg_en),
    .gcfg_leg   (gcfg_leg),
    .cnt_wr     (cnt_wr),
    .stat_wr    (stat_wr),
    .clr_bits   (reg_wdata[NUM_CH-1:0]),
    .cnt        (cnt),
    .cmp_wr     (cmp_wr),
    .lvl_vec    (lvl_vec),
    .per_vec    (per_vec),
    .status_vec (status_vec),
    .cmp_vec    (cmp_vec),
    .irq_req    (irq_req),
    .irq_line   (irq_line)
);

// File: tb/tb_evt_timer.sv
// Bench for evt_timer: a register vector table walked by one loop, then
// directed tests for timing, modes, status clearing, wrap and routing.
module tb_evt_timer;

    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     addr = '0;
    logic            we = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  irq_req;
    logic [NCH*5-1:0] irq_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_req   (irq_req),
        .irq_line  (irq_line)
    );

    // kind(1: read-check, 0: write), address, data, requirement number
    localparam int NV = 18;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 12'h000, 32'h1A2B8205, 4'd1},   // R1 identity
        {1'b1, 12'h004, 32'h00989680, 4'd1},   // R1 period
        {1'b0, 12'h004, 32'h12345678, 4'd1},
        {1'b1, 12'h004, 32'h00989680, 4'd1},   // R1 write ignored
        {1'b0, 12'h010, 32'h00000002, 4'd10},
        {1'b1, 12'h010, 32'h00000002, 4'd10},  // R10 legacy bit
        {1'b0, 12'h010, 32'h00000000, 4'd10},
        {1'b0, 12'h140, 32'h0000000C, 4'd9},
        {1'b1, 12'h140, 32'h00000004, 4'd9},   // R9 no periodic on ch2
        {1'b0, 12'h100, 32'h00000108, 4'd9},
        {1'b1, 12'h100, 32'h00000118, 4'd9},   // R9 capable ch0
        {1'b1, 12'h104, 32'h00F00F01, 4'd10},  // R10 allowed lines
        {1'b1, 12'h108, 32'h00000000, 4'd11},  // R11 comparator reset
        {1'b1, 12'h020, 32'h00000000, 4'd11},  // R11 status reset
        {1'b0, 12'h0F0, 32'h00001234, 4'd2},
        {1'b1, 12'h0F0, 32'h00001234, 4'd2},   // R2 load, held stopped
        {1'b0, 12'h100, 32'h00000000, 4'd9},
        {1'b0, 12'h140, 32'h00000000, 4'd9}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Samples counter and one request line per cycle
    task automatic watch(input int ch, input int n, output int pulses,
                         output logic [31:0] first, output int highs);
        logic prev = 1'b0;
        pulses = 0; highs = 0; first = '0;
        addr = 12'h0F0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
            if (irq_req[ch]) begin
                highs++;
                if (!prev) begin
                    if (pulses == 0) first = rdata;
                    pulses++;
                end
            end
            prev = irq_req[ch];
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int p, h;
        logic [31:0] f;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(irq_req == '0, "R11 irq", 32'(irq_req), 0);
        rd(12'h010, v); chk(v == 0, "R11 control", v, 0);
        rd(12'h0F0, v); chk(v == 0, "R11 counter", v, 0);
        @(negedge clk);
        rd(12'h0F0, v); chk(v == 0, "R2 hold while stopped", v, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][48]) begin
                rd(VEC[i][47:36], v);
                chk(v == VEC[i][35:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i),
                    v, VEC[i][35:4]);
            end else begin
                wr(VEC[i][47:36], VEC[i][35:4]);
            end
        end

        // R3 edge one-shot on ch0
        wr(12'h108, 32'd105); wr(12'h100, 32'h4); wr(12'h0F0, 32'd100); wr(12'h010, 32'h1);
        watch(0, 15, p, f, h);
        chk(p == 1 && h == 1, "R3 single pulse", 32'(h), 1);
        chk(f == 32'd106, "R3 pulse timing", f, 106);
        wr(12'h010, 32'h0);
        rd(12'h020, v); chk(v[0] == 1'b0, "R3 no status in edge", v, 0);
        rd(12'h108, v); chk(v == 32'd105, "R6 comparator kept", v, 105);

        // R3 interrupt disabled
        wr(12'h100, 32'h0); wr(12'h0F0, 32'd100); wr(12'h010, 32'h1);
        watch(0, 15, p, f, h);
        chk(p == 0, "R3 disabled no pulse", 32'(p), 0);
        wr(12'h010, 32'h0);

        // R6 one-shot on ch2
        wr(12'h148, 32'd50); wr(12'h140, 32'h4); wr(12'h0F0, 32'd45); wr(12'h010, 32'h1);
        watch(2, 30, p, f, h);
        chk(p == 1 && f == 32'd51, "R6 one-shot fires once", f, 51);
        wr(12'h010, 32'h0);
        rd(12'h148, v); chk(v == 32'd50, "R6 comparator kept", v, 50);
        wr(12'h140, 32'h0);

        // R7 periodic with set-value on ch0
        wr(12'h100, 32'h4C);
        rd(12'h100, v); chk(v == 32'h5C, "R7 cfg armed", v, 32'h5C);
        wr(12'h108, 32'd200);
        rd(12'h100, v); chk(v == 32'h5C, "R7 set-value after first write", v, 32'h5C);
        wr(12'h108, 32'd10);
        rd(12'h100, v); chk(v == 32'h1C, "R7 set-value cleared", v, 32'h1C);
        rd(12'h108, v); chk(v == 32'd200, "R7 first write is match", v, 200);
        wr(12'h0F0, 32'd190); wr(12'h010, 32'h1);
        watch(0, 35, p, f, h);
        chk(p == 3 && f == 32'd201, "R7 periodic pulses", 32'(p), 3);
        wr(12'h010, 32'h0);
        rd(12'h108, v); chk(v == 32'd230, "R7 comparator advanced", v, 230);

        // R8 periodic rewrite keeps increment
        wr(12'h108, 32'd300);
        rd(12'h108, v); chk(v == 32'd300, "R8 match rewrite", v, 300);
        wr(12'h0F0, 32'd295); wr(12'h010, 32'h1);
        watch(0, 20, p, f, h);
        chk(p == 2 && f == 32'd301, "R8 increment kept", 32'(p), 2);
        wr(12'h010, 32'h0);
        rd(12'h108, v); chk(v == 32'd320, "R8 comparator advanced", v, 320);
        wr(12'h100, 32'h0);

        // R4 and R5 level on ch1
        wr(12'h128, 32'd70); wr(12'h120, 32'h6); wr(12'h0F0, 32'd65); wr(12'h010, 32'h1);
        watch(1, 15, p, f, h);
        chk(f == 32'd71 && h == 10 && p == 1, "R4 level held", 32'(h), 10);
        wr(12'h010, 32'h0);
        rd(12'h020, v); chk(v == 32'h2, "R4 status set", v, 2);
        wr(12'h020, 32'h1);
        rd(12'h020, v); chk(v == 32'h2, "R5 other bit no effect", v, 2);
        chk(irq_req[1] == 1'b1, "R4 still requesting", 32'(irq_req), 2);
        wr(12'h020, 32'h2);
        rd(12'h020, v); chk(v == 32'h0, "R5 write-one clears", v, 0);
        chk(irq_req[1] == 1'b0, "R4 request drops", 32'(irq_req), 0);
        wr(12'h0F0, 32'd65); wr(12'h010, 32'h1);
        watch(1, 10, p, f, h);
        wr(12'h010, 32'h0);
        rd(12'h020, v); chk(v == 32'h2, "R4 status set again", v, 2);
        wr(12'h020, 32'hFFFFFFFF);
        rd(12'h020, v); chk(v == 32'h0, "R5 all ones clears", v, 0);
        wr(12'h120, 32'h0);

        // R2 wrap while running
        wr(12'h010, 32'h1); wr(12'h0F0, 32'hFFFFFFFE);
        rd(12'h0F0, v); chk(v == 32'hFFFFFFFE, "R2 load running", v, 32'hFFFFFFFE);
        @(negedge clk); #1;
        chk(rdata == 32'hFFFFFFFF, "R2 step", rdata, 32'hFFFFFFFF);
        @(negedge clk); #1;
        chk(rdata == 32'h0, "R2 wrap", rdata, 0);
        wr(12'h010, 32'h0);

        // R10 routing and legacy override
        wr(12'h100, 32'hA00); wr(12'h120, 32'hC00); wr(12'h140, 32'hE00);
        #1;
        chk(irq_line == {5'd7, 5'd6, 5'd5}, "R10 route fields", 32'(irq_line),
            32'({5'd7, 5'd6, 5'd5}));
        wr(12'h010, 32'h2);
        #1;
        chk(irq_line == {5'd7, 5'd8, 5'd0}, "R10 legacy override", 32'(irq_line),
            32'({5'd7, 5'd8, 5'd0}));
        wr(12'h010, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule